// File: doc/BRIEF.md
# Reset Sequence Controller

This block gathers the three ways a small controller can be sent into reset: an active-low reset pad driven from outside, a low-supply flag from an analog voltage monitor, and a one-cycle watchdog underflow strobe. It merges them into one internal reset for the core, and it drives the shared reset pad low itself when the cause is internal. Once every cause has gone away it holds the core in reset for a programmable settling delay. It then issues a one-cycle strobe that starts the fetch of the reset vector.

Both asynchronous inputs, the pad level and the low-supply flag, pass through a synchronizer and a stability filter, so spikes and short glitches are ignored. A watchdog strobe always produces a pad pulse of a guaranteed minimum width. The pad is treated as open-drain: after the block stops pulling it, the block waits until the pad is sensed high through the same filter. A pad that is still held low from outside keeps the core in reset. A three-bit cause register records which source started the most recent sequence. Software clears it with a write-one-to-clear strobe while the core runs.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_pin_pull_o`=1, `core_rst_o`=1, `vec_fetch_o`=0 and `cause_o`=3'b010. The cause bits are [2] watchdog, [1] low supply and [0] external pad. After `por_n` is released, the power-on sequence runs like a low-supply reset and ends in a vector fetch.
- R2: An external low level on `rst_pin_i` is accepted only if it lasts at least PIN_FILT consecutive cycles. In that case `core_rst_o` rises exactly PIN_FILT+3 cycles after the first low cycle. A shorter low pulse causes no reset and leaves `cause_o` unchanged.
- R3: A high level on `low_volt_i` that lasts at least LV_FILT consecutive cycles starts a sequence with the pad pulled low. The pad stays pulled while the filtered flag is high. Shorter spikes are ignored.
- R4: A single-cycle `wdt_uflow_i` strobe pulls the pad low starting in the next cycle, for exactly WDG_PULSE consecutive cycles when no other cause is present.
- R5: The pad pull is released only when the filtered low-supply flag is clear, the watchdog pulse has elapsed, and the pad is already sensed low through its filter.
- R6: `vec_fetch_o` rises exactly PIN_FILT+N+3 cycles after the pad returns high. N is DLY_SHORT (256) when `dly_long_i`=0 and DLY_LONG (4096) when it is 1. The option is sampled when the delay starts, and `core_rst_o` stays high until that cycle.
- R7: `vec_fetch_o` is high for exactly one cycle. `core_rst_o` is low in that cycle and stays low afterwards until a new cause arrives.
- R8: At the start of a sequence `cause_o` is loaded with exactly one bit set. The priority is low supply, then watchdog, then external pad.
- R9: While the core runs, each 1 bit of `cause_clr_i` clears the matching bit of `cause_o` and each 0 bit leaves its bit unchanged. Outside the run phase `cause_clr_i` has no effect.
- R10: A new cause during the settling delay restarts the sequence. No vector fetch happens for the abandoned delay, a watchdog strobe pulls the pad again, and `cause_o` is replaced.
- R11: If the pad still reads low after the pull ends, the core is held in reset. The settling delay then counts from the moment the pad is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset of the sequencer itself, active low |
| rst_pin_i | input | 1 | Raw level read back from the reset pad |
| low_volt_i | input | 1 | Low-supply flag from the voltage monitor, high while supply is low |
| wdt_uflow_i | input | 1 | Watchdog underflow strobe |
| dly_long_i | input | 1 | Option bit: 0 selects the short settling delay, 1 the long one |
| cause_clr_i | input | 3 | Write-one-to-clear strobe for the cause bits |
| rst_pin_pull_o | output | 1 | Pad pull-down enable |
| core_rst_o | output | 1 | Internal reset to the core |
| vec_fetch_o | output | 1 | One-cycle strobe that starts the reset-vector fetch |
| cause_o | output | 3 | Latched cause of the last reset sequence |

## Verification
The hardest situations to reach are a cause that lands inside the settling window, and a pad that is still held low from outside when a watchdog pulse ends. Neither shows up as a distinct port event. The bench times every stimulus from the cycle at which the pad was sensed high again. It places a watchdog strobe well inside the short delay, and it asserts the external pad together with a watchdog strobe and keeps it low past the end of the pull. It then checks that exactly one vector fetch follows, timed from the final pad release.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_DRIVE,
    ST_HOLD,
    ST_DELAY,
    ST_FETCH
  } seq_state_e;

  // bit 2 watchdog, bit 1 low supply, bit 0 external pad
  typedef struct packed {
    logic wdt;
    logic lowv;
    logic pad;
  } cause_t;

  function automatic int unsigned count_width(int unsigned max_val);
    if (max_val < 2) return 1;
    return $clog2(max_val + 1);
  endfunction

  function automatic int unsigned delay_len(logic sel_long, int unsigned n_short,
                                            int unsigned n_long);
    return sel_long ? n_long : n_short;
  endfunction

  function automatic cause_t cause_pick(logic lv, logic wd, logic px);
    cause_t c;
    c = '0;
    if (lv)      c.lowv = 1'b1;
    else if (wd) c.wdt  = 1'b1;
    else if (px) c.pad  = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/rstseq_filter.sv
module rstseq_filter #(
  parameter int unsigned STAGES     = 2,
  parameter int unsigned LEN        = 16,
  parameter bit          RST_ACTIVE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic act_o
);
  localparam int unsigned CW   = rstseq_pkg::count_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [STAGES-1:0] sync_q;
  logic [CW-1:0]     run_q;
  logic              lvl_q;
  logic              differs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_ACTIVE}};
    end else begin
      sync_q[0] <= raw_i;
      for (int i = 1; i < int'(STAGES); i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign differs = sync_q[STAGES-1] ^ lvl_q;

  // level is taken over only after LEN consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= RST_ACTIVE;
    end else if (!differs) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q <= '0;
      lvl_q <= sync_q[STAGES-1];
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign act_o = lvl_q;
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
  parameter int unsigned WIDTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = rstseq_pkg::count_width(WIDTH);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start_i)        left_q <= CW'(WIDTH - 1);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay #(
  parameter int unsigned MAXLEN = 4096,
  localparam int unsigned DW    = rstseq_pkg::count_width(MAXLEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] len_i,
  output logic          done_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PIN_FILT    = 16,
  parameter int unsigned LV_FILT     = 8,
  parameter int unsigned WDG_PULSE   = 64,
  parameter int unsigned DLY_SHORT   = 256,
  parameter int unsigned DLY_LONG    = 4096
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_pin_i,
  input  logic       low_volt_i,
  input  logic       wdt_uflow_i,
  input  logic       dly_long_i,
  input  logic [2:0] cause_clr_i,
  output logic       rst_pin_pull_o,
  output logic       core_rst_o,
  output logic       vec_fetch_o,
  output logic [2:0] cause_o
);
  import rstseq_pkg::*;

  localparam int unsigned DLY_MAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
  localparam int unsigned DW      = count_width(DLY_MAX);

  seq_state_e state_q, state_d;
  cause_t     cause_q, cap_val;
  logic       cap;

  // named internal events, also observed by the checker
  logic lv_act;
  logic pin_act;
  logic wdt_busy;
  logic dly_done;
  logic dly_load;
  logic in_run;
  logic seq_start;
  logic any_cause;
  logic [DW-1:0] dly_len;

  rstseq_filter #(.STAGES(SYNC_STAGES), .LEN(PIN_FILT), .RST_ACTIVE(1'b1)) u_pin_filt (
    .clk(clk), .rst_n(por_n), .raw_i(~rst_pin_i), .act_o(pin_act)
  );

  rstseq_filter #(.STAGES(SYNC_STAGES), .LEN(LV_FILT), .RST_ACTIVE(1'b1)) u_lv_filt (
    .clk(clk), .rst_n(por_n), .raw_i(low_volt_i), .act_o(lv_act)
  );

  rstseq_stretch #(.WIDTH(WDG_PULSE)) u_wdt_pulse (
    .clk(clk), .rst_n(por_n), .start_i(wdt_uflow_i), .busy_o(wdt_busy)
  );

  assign dly_len = DW'(delay_len(dly_long_i, DLY_SHORT, DLY_LONG));

  rstseq_delay #(.MAXLEN(DLY_MAX)) u_delay (
    .clk(clk), .rst_n(por_n), .load_i(dly_load), .len_i(dly_len), .done_o(dly_done)
  );

  assign any_cause = lv_act | wdt_uflow_i | pin_act;

  always_comb begin
    state_d  = state_q;
    cap      = 1'b0;
    cap_val  = cause_pick(lv_act, wdt_uflow_i, pin_act);
    dly_load = 1'b0;
    unique case (state_q)
      ST_RUN, ST_FETCH: begin
        if (any_cause) begin
          cap     = 1'b1;
          state_d = (lv_act | wdt_uflow_i) ? ST_DRIVE : ST_HOLD;
        end else begin
          state_d = ST_RUN;
        end
      end
      ST_DRIVE: begin
        // release only once our own pull has been sensed on the pad
        if (!lv_act && !wdt_uflow_i && !wdt_busy && pin_act) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (lv_act | wdt_uflow_i) begin
          cap     = 1'b1;
          state_d = ST_DRIVE;
        end else if (!pin_act) begin
          dly_load = 1'b1;
          state_d  = ST_DELAY;
        end
      end
      ST_DELAY: begin
        if (any_cause) begin
          cap     = 1'b1;
          state_d = (lv_act | wdt_uflow_i) ? ST_DRIVE : ST_HOLD;
        end else if (dly_done) begin
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_DRIVE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= ST_DRIVE;
    else        state_q <= state_d;
  end

  assign in_run    = (state_q == ST_RUN);
  assign seq_start = cap;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cause_q <= '{wdt: 1'b0, lowv: 1'b1, pad: 1'b0};
    else if (cap)    cause_q <= cap_val;
    else if (in_run) cause_q <= cause_t'(cause_q & ~cause_clr_i);
  end

  assign rst_pin_pull_o = (state_q == ST_DRIVE);
  assign vec_fetch_o    = (state_q == ST_FETCH);
  assign core_rst_o     = !(in_run || vec_fetch_o);
  assign cause_o        = cause_q;
endmodule

// File: rtl/rstseq_ctrl_sva.sv
module rstseq_ctrl_sva (
  input logic       clk,
  input logic       por_n,
  input logic       wdt_uflow_i,
  input logic       pull,
  input logic       core_rst,
  input logic       vec,
  input logic [2:0] cause,
  input logic       in_run,
  input logic       lv_act,
  input logic       pin_act,
  input logic       wdt_busy,
  input logic       dly_done,
  input logic       seq_start
);
  a_r7_fetch_single: assert property (@(posedge clk) disable iff (!por_n)
    vec |=> !vec);

  a_r7_fetch_core_free: assert property (@(posedge clk) disable iff (!por_n)
    vec |-> !core_rst);

  a_r6_fetch_after_count: assert property (@(posedge clk) disable iff (!por_n)
    vec |-> $past(dly_done));

  a_r3_low_supply_pulls: assert property (@(posedge clk) disable iff (!por_n)
    lv_act |=> pull);

  a_r4_wdt_pulls: assert property (@(posedge clk) disable iff (!por_n)
    wdt_uflow_i |=> pull);

  a_r5_release_after_pulse: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pull) |-> ($past(!wdt_busy) && $past(pin_act) && $past(!lv_act)));

  a_r8_cause_onehot: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(cause));

  a_r9_cause_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (!in_run && !seq_start) |=> $stable(cause));

  a_r11_pad_low_holds: assert property (@(posedge clk) disable iff (!por_n)
    pin_act |=> core_rst);
endmodule

bind rstseq_ctrl rstseq_ctrl_sva u_sva (
  .clk(clk), .por_n(por_n), .wdt_uflow_i(wdt_uflow_i), .pull(rst_pin_pull_o),
  .core_rst(core_rst_o), .vec(vec_fetch_o), .cause(cause_o), .in_run(in_run),
  .lv_act(lv_act), .pin_act(pin_act), .wdt_busy(wdt_busy), .dly_done(dly_done),
  .seq_start(seq_start)
);

// File: tb/rstseq_ctrl_bench.sv
module rstseq_ctrl_bench;
  localparam int PF = 16;
  localparam int LF = 8;
  localparam int WP = 64;
  localparam int NS = 256;
  localparam int NL = 4096;
  localparam int TW = 23;

  // fields: kind[22:21] (0 pad,1 supply,2 watchdog) len[20:5] long[4] reset[3] cause[2:0]
  localparam logic [TW-1:0] TBL [0:7] = '{
    {2'd0, 16'(PF-1), 1'b0, 1'b0, 3'b000},
    {2'd0, 16'(PF),   1'b0, 1'b1, 3'b001},
    {2'd0, 16'(PF+20),1'b0, 1'b1, 3'b001},
    {2'd1, 16'(LF-1), 1'b0, 1'b0, 3'b000},
    {2'd1, 16'(LF),   1'b0, 1'b1, 3'b010},
    {2'd1, 16'd40,    1'b1, 1'b1, 3'b010},
    {2'd2, 16'd1,     1'b0, 1'b1, 3'b100},
    {2'd2, 16'd1,     1'b1, 1'b1, 3'b100}
  };

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ext_low = 1'b0, low_volt = 1'b0, wdt_pulse = 1'b0, dly_long = 1'b0;
  logic [2:0] cause_clr = 3'b000;
  logic pull, core_rst, vec;
  logic [2:0] cause;
  logic pin_w;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  int cyc = 0, ext_start_cyc = 0, pin_rise_cyc = 0, rst_rise_cyc = 0, vec_cyc = 0;
  int vec_count = 0, drive_len = 0;
  logic ext_prev = 1'b0, pin_prev = 1'b0, rst_prev = 1'b0, drv_prev = 1'b0;

  always #5 clk = ~clk;

  assign pin_w = (ext_low || pull) ? 1'b0 : 1'b1;

  rstseq_ctrl #(.SYNC_STAGES(2), .PIN_FILT(PF), .LV_FILT(LF), .WDG_PULSE(WP),
                .DLY_SHORT(NS), .DLY_LONG(NL)) u_rstseq_ctrl (
    .clk(clk), .por_n(por_n), .rst_pin_i(pin_w), .low_volt_i(low_volt),
    .wdt_uflow_i(wdt_pulse), .dly_long_i(dly_long), .cause_clr_i(cause_clr),
    .rst_pin_pull_o(pull), .core_rst_o(core_rst), .vec_fetch_o(vec), .cause_o(cause)
  );

  // observer: samples late in each cycle, after negedge-driven stimulus
  always @(negedge clk) begin
    #3;
    cyc++;
    if (ext_low && !ext_prev) ext_start_cyc = cyc;
    if (pin_w === 1'b1 && !pin_prev) pin_rise_cyc = cyc;
    if (core_rst === 1'b1 && !rst_prev) rst_rise_cyc = cyc;
    if (vec === 1'b1) begin vec_cyc = cyc; vec_count++; end
    if (pull === 1'b1 && !drv_prev) drive_len = 0;
    if (pull === 1'b1) drive_len++;
    ext_prev = ext_low;
    pin_prev = (pin_w === 1'b1);
    rst_prev = (core_rst === 1'b1);
    drv_prev = (pull === 1'b1);
  end

  task automatic check_eq(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_vec(int base, int max_cyc);
    int n = 0;
    while (vec_count == base && n < max_cyc) begin
      @(negedge clk); #4; n++;
    end
  endtask

  task automatic clear_all_cause();
    @(negedge clk); cause_clr = 3'b111;
    @(negedge clk); cause_clr = 3'b000;
    #4 check_eq("R9", "cause after clear in run", int'(cause), 0);
  endtask

  task automatic run_entry(int idx);
    logic [TW-1:0] e;
    int kind, len, n_dly, base_rst, base_vec;
    e = TBL[idx];
    kind = int'(e[22:21]); len = int'(e[20:5]);
    n_dly = e[4] ? NL : NS;
    base_rst = rst_rise_cyc; base_vec = vec_count;
    @(negedge clk);
    dly_long = e[4];
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      if (kind == 0) ext_low = 1'b1;
      else if (kind == 1) low_volt = 1'b1;
      else wdt_pulse = 1'b1;
    end
    @(negedge clk);
    ext_low = 1'b0; low_volt = 1'b0; wdt_pulse = 1'b0;
    if (!e[3]) begin
      repeat (3*PF) @(negedge clk);
      #4;
      check_eq(kind == 0 ? "R2" : "R3", "short pulse started no reset", rst_rise_cyc, base_rst);
      check_eq(kind == 0 ? "R2" : "R3", "core reset after short pulse", int'(core_rst), 0);
      check_eq(kind == 0 ? "R2" : "R3", "cause after short pulse", int'(cause), 0);
    end else begin
      wait_vec(base_vec, 6000);
      check_eq("R6", "vector fetch arrived", vec_count, base_vec + 1);
      check_eq("R6", "fetch delay from pad release", vec_cyc - pin_rise_cyc, PF + n_dly + 3);
      check_eq("R7", "core reset in fetch cycle", int'(core_rst), 0);
      check_eq("R8", "cause one-hot", int'(cause), int'(e[2:0]));
      if (kind == 0) check_eq("R2", "core reset rise latency", rst_rise_cyc - ext_start_cyc, PF + 3);
      if (kind == 1) check_eq("R3", "pad pulled on low supply", int'(drive_len > 0), 1);
      if (kind == 2) check_eq("R4", "watchdog pull width", drive_len, WP);
      @(negedge clk); #4;
      check_eq("R7", "fetch strobe one cycle", int'(vec), 0);
      check_eq("R7", "core stays out of reset", int'(core_rst), 0);
    end
    clear_all_cause();
  endtask

  initial begin
    int base;
    // R1: reset values
    repeat (3) @(negedge clk);
    #4;
    check_eq("R1", "pull in reset", int'(pull), 1);
    check_eq("R1", "core reset in reset", int'(core_rst), 1);
    check_eq("R1", "fetch in reset", int'(vec), 0);
    check_eq("R1", "cause in reset", int'(cause), 2);
    @(negedge clk); por_n = 1'b1;
    base = vec_count;
    wait_vec(base, 2000);
    check_eq("R1", "power-on sequence fetch", vec_count, base + 1);
    check_eq("R6", "power-on delay from pad release", vec_cyc - pin_rise_cyc, PF + NS + 3);
    check_eq("R1", "power-on cause", int'(cause), 2);

    // R9: partial clear keeps bits written 0
    @(negedge clk); cause_clr = 3'b101;
    @(negedge clk); cause_clr = 3'b000;
    #4 check_eq("R9", "clear with zero bit on set cause", int'(cause), 2);
    @(negedge clk); cause_clr = 3'b010;
    @(negedge clk); cause_clr = 3'b000;
    #4 check_eq("R9", "matching clear bit", int'(cause), 0);

    for (int k = 0; k < 8; k++) run_entry(k);

    // R10: watchdog during the settling delay restarts the sequence
    dly_long = 1'b0;
    base = vec_count;
    @(negedge clk); ext_low = 1'b1;
    repeat (20) @(negedge clk);
    ext_low = 1'b0;
    repeat (60) @(negedge clk);
    #4;
    check_eq("R10", "in delay core reset", int'(core_rst), 1);
    @(negedge clk); cause_clr = 3'b111;
    @(negedge clk); cause_clr = 3'b000;
    #4 check_eq("R9", "clear ignored outside run", int'(cause), 1);
    @(negedge clk); wdt_pulse = 1'b1;
    @(negedge clk); wdt_pulse = 1'b0;
    #4;
    check_eq("R10", "pad pulled again", int'(pull), 1);
    check_eq("R10", "cause replaced", int'(cause), 4);
    wait_vec(base, 2000);
    @(negedge clk); #4;
    check_eq("R10", "single fetch after restart", vec_count, base + 1);
    check_eq("R10", "delay counted from last release", vec_cyc - pin_rise_cyc, PF + NS + 3);
    clear_all_cause();

    // R11: pad held low from outside beyond the watchdog pull
    base = vec_count;
    @(negedge clk); ext_low = 1'b1; wdt_pulse = 1'b1;
    @(negedge clk); wdt_pulse = 1'b0;
    repeat (WP + 40) @(negedge clk);
    #4;
    check_eq("R11", "pull ended while pad held", int'(pull), 0);
    check_eq("R11", "core held while pad low", int'(core_rst), 1);
    check_eq("R11", "no fetch while pad low", vec_count, base);
    check_eq("R4", "pull width with pad held", drive_len, WP);
    @(negedge clk); ext_low = 1'b0;
    wait_vec(base, 2000);
    check_eq("R11", "delay from external release", vec_cyc - pin_rise_cyc, PF + NS + 3);
    check_eq("R8", "watchdog wins over pad", int'(cause), 4);
    clear_all_cause();

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule